// File: doc/BRIEF.md
# Ring-Oscillator Frequency Error Front End

This block is the digital front end of a supply regulation loop. An on-chip ring oscillator runs at a frequency that depends on the supply voltage. The block counts the oscillator's rising edges over a fixed window that is timed by the reference clock. The result is a quantized frequency word.

Software places a target frequency in a control register. The block subtracts the measured word from that target and produces a signed error. A hybrid modulator then turns the error into enables for a high-side and a low-side power switch. A large positive error gives pulse-width drive, with the duty set by the error. A small positive error gives sparse fixed-length pulses. A zero error gives no drive. A negative error blocks the high side at once.

The count crosses from the oscillator clock into the reference clock through a toggle request and acknowledge pair. Each side of the pair passes through two synchronizing flops, so the reference side always takes a settled word.

Top module: `dvs_freq_err_unit`

## Requirements
- R1: Each measurement equals the number of oscillator rising edges in one window of WIN_CYCLES reference cycles (default 100). With an oscillator period that divides the window exactly, the measurement is exactly window/period.
- R2: The measurement saturates at 127 and does not wrap when the oscillator is faster.
- R3: The 7-bit target register loads `tgt_wr_data` on a reference edge where `tgt_wr_en` is high. It keeps its value when `tgt_wr_en` is low.
- R4: `freq_err` is the 8-bit two's complement value of target minus measurement. It follows the registered target and measurement one reference cycle later.
- R5: `meas_valid` is high for one cycle each time a new measurement is taken. `freq_meas` changes only in such a cycle.
- R6: When the error is zero, `drive_mode` is 1 (idle) and `hs_en` stays low.
- R7: When the error is 1 to 7, `drive_mode` is 2 (pulse-frequency). The block gives one 3-cycle high-side pulse every 4 periods of 16 cycles, which is 3 high cycles in every 64.
- R8: When the error is 8 or more, `drive_mode` is 3 (pulse-width). `hs_en` is high for min(error,16) cycles of each 16-cycle period.
- R9: When the error is negative, `drive_mode` is 0 (off). `hs_en` is low from the cycle after `freq_err` turns negative, and no pulse is issued while the error stays negative.
- R10: `ls_en` is always the complement of `hs_en`.
- R11: During reset, `freq_meas` and `freq_err` are 0, `hs_en` is 0 and `ls_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the window and clocks the error and modulator logic |
| osc_clk | input | 1 | Ring-oscillator clock whose edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| tgt_wr_en | input | 1 | Write strobe for the target frequency register |
| tgt_wr_data | input | 7 | Target frequency value to be written |
| freq_meas | output | 7 | Latest measured frequency word |
| meas_valid | output | 1 | One-cycle pulse when `freq_meas` updates |
| freq_err | output | 8 | Signed error: target minus measurement |
| drive_mode | output | 2 | 0 off, 1 idle, 2 pulse-frequency, 3 pulse-width |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |

## Verification
A wrong edge count or a lost handshake shows up on `freq_meas` one or two windows later, as a value off from window/period or as a word that stops updating. A corrupted target register or subtractor shows on `freq_err` within two reference cycles of a write. A bad modulator phase or skip counter shows as a wrong count of high cycles on `hs_en` over a 64-cycle span. A broken negative-error block shows on `hs_en` within two cycles after `freq_err` turns negative.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_PFM  = 2'd2,
        MODE_PWM  = 2'd3
    } drive_mode_e;
endpackage

// File: rtl/osc_window_counter.sv
// Oscillator-domain edge counter: latches and restarts on each request toggle.
module osc_window_counter #(
    parameter int CNT_W = 7
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             req_tgl_i,
    output logic [CNT_W-1:0] cnt_word_o,
    output logic             ack_tgl_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [2:0]       req_sync;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             ack;
    } osc_state_t;

    logic [1:0] rst_sync_q;
    logic       osc_rst_n;
    osc_state_t st_d, st_q;
    logic       det;

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= 2'b00;
        else        rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
    assign osc_rst_n = rst_sync_q[1];

    always_comb begin
        st_d          = st_q;
        st_d.req_sync = {st_q.req_sync[1:0], req_tgl_i};
        det           = st_q.req_sync[1] ^ st_q.req_sync[2];
        if (det) begin
            st_d.hold = st_q.cnt;
            st_d.cnt  = CNT_ONE;
            st_d.ack  = ~st_q.ack;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign cnt_word_o = st_q.hold;
    assign ack_tgl_o  = st_q.ack;
endmodule

// File: rtl/ref_meas_capture.sv
// Reference-domain window timer and capture side of the handshake.
module ref_meas_capture #(
    parameter int CNT_W      = 7,
    parameter int WIN_CYCLES = 100
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             ack_tgl_i,
    input  logic [CNT_W-1:0] cnt_word_i,
    output logic             req_tgl_o,
    output logic [CNT_W-1:0] meas_o,
    output logic             valid_o
);
    localparam int WIN_W = $clog2(WIN_CYCLES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             req;
        logic [2:0]       ack_sync;
        logic [CNT_W-1:0] meas;
        logic             valid;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       ack_new;

    always_comb begin
        st_d          = st_q;
        st_d.ack_sync = {st_q.ack_sync[1:0], ack_tgl_i};
        ack_new       = st_q.ack_sync[1] ^ st_q.ack_sync[2];
        st_d.valid    = ack_new;
        if (ack_new) st_d.meas = cnt_word_i;
        if (st_q.win == WIN_LAST) begin
            if (st_q.req == st_q.ack_sync[2]) begin
                st_d.req = ~st_q.req;
                st_d.win = '0;
            end
        end else begin
            st_d.win = st_q.win + WIN_ONE;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tgl_o = st_q.req;
    assign meas_o    = st_q.meas;
    assign valid_o   = st_q.valid;
endmodule

// File: rtl/target_error_unit.sv
// Target register and signed error subtractor.
module target_error_unit #(
    parameter int CNT_W = 7,
    parameter int ERR_W = CNT_W + 1
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] meas_i,
    output logic [CNT_W-1:0] tgt_o,
    output logic [ERR_W-1:0] err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] tgt;
        logic [ERR_W-1:0] err;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        if (wr_en_i) st_d.tgt = wr_data_i;
        st_d.err = ERR_W'({1'b0, st_q.tgt}) - ERR_W'({1'b0, meas_i});
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_o = st_q.tgt;
    assign err_o = st_q.err;
endmodule

// File: rtl/hybrid_modulator.sv
// Pulse-width / pulse-frequency drive generator for the power switches.
module hybrid_modulator
    import dvs_pkg::*;
#(
    parameter int ERR_W     = 8,
    parameter int PW_BITS   = 4,
    parameter int PFM_BAND  = 8,
    parameter int PFM_PULSE = 3,
    parameter int PFM_SKIP  = 4
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_i,
    output logic             hs_en_o,
    output logic             ls_en_o,
    output logic [1:0]       mode_o
);
    localparam int PERIOD = 1 << PW_BITS;
    localparam int DUTY_W = PW_BITS + 1;
    localparam int SKIP_W = $clog2(PFM_SKIP + 1);
    localparam logic [ERR_W-1:0]  BAND_E   = ERR_W'(PFM_BAND);
    localparam logic [ERR_W-1:0]  PERIOD_E = ERR_W'(PERIOD);
    localparam logic [DUTY_W-1:0] FULL_D   = DUTY_W'(PERIOD);
    localparam logic [DUTY_W-1:0] PULSE_D  = DUTY_W'(PFM_PULSE);
    localparam logic [SKIP_W-1:0] SKIP_RLD = SKIP_W'(PFM_SKIP - 1);
    localparam logic [SKIP_W-1:0] SKIP_ONE = SKIP_W'(1);
    localparam logic [PW_BITS-1:0] PH_ONE  = PW_BITS'(1);

    typedef struct packed {
        logic [PW_BITS-1:0] phase;
        logic [DUTY_W-1:0]  duty;
        logic [SKIP_W-1:0]  skip;
        drive_mode_e        mode;
        logic               hs;
        logic               ls;
    } mod_state_t;

    mod_state_t st_d, st_q;
    logic       neg;

    always_comb begin
        st_d       = st_q;
        neg        = err_i[ERR_W-1];
        st_d.phase = st_q.phase + PH_ONE;
        if (st_q.phase == '0) begin
            if (neg) begin
                st_d.mode = MODE_OFF;
                st_d.duty = '0;
                st_d.skip = '0;
            end else if (err_i == '0) begin
                st_d.mode = MODE_IDLE;
                st_d.duty = '0;
                st_d.skip = '0;
            end else if (err_i < BAND_E) begin
                st_d.mode = MODE_PFM;
                if (st_q.skip == '0) begin
                    st_d.duty = PULSE_D;
                    st_d.skip = SKIP_RLD;
                end else begin
                    st_d.duty = '0;
                    st_d.skip = st_q.skip - SKIP_ONE;
                end
            end else begin
                st_d.mode = MODE_PWM;
                st_d.duty = (err_i >= PERIOD_E) ? FULL_D : DUTY_W'(err_i);
                st_d.skip = '0;
            end
        end
        st_d.hs = ({1'b0, st_q.phase} < st_d.duty) && !neg;
        st_d.ls = !st_d.hs;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_IDLE;
            st_q.ls   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_en_o = st_q.hs;
    assign ls_en_o = st_q.ls;
    assign mode_o  = st_q.mode;
endmodule

// File: rtl/dvs_freq_err_unit.sv
module dvs_freq_err_unit #(
    parameter int CNT_W      = 7,
    parameter int WIN_CYCLES = 100,
    parameter int PW_BITS    = 4,
    parameter int PFM_BAND   = 8,
    parameter int PFM_PULSE  = 3,
    parameter int PFM_SKIP   = 4
) (
    input  logic             ref_clk,
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             tgt_wr_en,
    input  logic [CNT_W-1:0] tgt_wr_data,
    output logic [CNT_W-1:0] freq_meas,
    output logic             meas_valid,
    output logic [CNT_W:0]   freq_err,
    output logic [1:0]       drive_mode,
    output logic             hs_en,
    output logic             ls_en
);
    localparam int ERR_W = CNT_W + 1;

    logic             req_tgl;
    logic             ack_tgl;
    logic [CNT_W-1:0] osc_word;
    logic [CNT_W-1:0] tgt_word;

    osc_window_counter #(.CNT_W(CNT_W)) u_osc (
        .osc_clk    (osc_clk),
        .rst_n      (rst_n),
        .req_tgl_i  (req_tgl),
        .cnt_word_o (osc_word),
        .ack_tgl_o  (ack_tgl)
    );

    ref_meas_capture #(.CNT_W(CNT_W), .WIN_CYCLES(WIN_CYCLES)) u_cap (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .ack_tgl_i  (ack_tgl),
        .cnt_word_i (osc_word),
        .req_tgl_o  (req_tgl),
        .meas_o     (freq_meas),
        .valid_o    (meas_valid)
    );

    target_error_unit #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_err (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .wr_en_i   (tgt_wr_en),
        .wr_data_i (tgt_wr_data),
        .meas_i    (freq_meas),
        .tgt_o     (tgt_word),
        .err_o     (freq_err)
    );

    hybrid_modulator #(
        .ERR_W    (ERR_W),
        .PW_BITS  (PW_BITS),
        .PFM_BAND (PFM_BAND),
        .PFM_PULSE(PFM_PULSE),
        .PFM_SKIP (PFM_SKIP)
    ) u_mod (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .err_i   (freq_err),
        .hs_en_o (hs_en),
        .ls_en_o (ls_en),
        .mode_o  (drive_mode)
    );
endmodule

// File: rtl/dvs_freq_err_unit_chk.sv
module dvs_freq_err_unit_chk #(
    parameter int CNT_W = 7
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             tgt_wr_en,
    input logic [CNT_W-1:0] tgt_wr_data,
    input logic [CNT_W-1:0] tgt_word,
    input logic [CNT_W-1:0] freq_meas,
    input logic             meas_valid,
    input logic [CNT_W:0]   freq_err,
    input logic [1:0]       drive_mode,
    input logic             hs_en
);
    assert_tgt_load_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        tgt_wr_en |=> tgt_word == $past(tgt_wr_data));

    assert_tgt_hold_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !tgt_wr_en |=> $stable(tgt_word));

    assert_err_track_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        1'b1 |=> freq_err == ((CNT_W+1)'({1'b0, $past(tgt_word)}) - (CNT_W+1)'({1'b0, $past(freq_meas)})));

    assert_meas_only_on_valid_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$stable(freq_meas) |-> meas_valid);

    assert_idle_no_drive_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        drive_mode == 2'd1 |-> !hs_en);

    assert_neg_blocks_hs_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        freq_err[CNT_W] |=> !hs_en);

    assert_off_no_drive_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        drive_mode == 2'd0 |-> !hs_en);
endmodule

bind dvs_freq_err_unit dvs_freq_err_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .tgt_wr_en   (tgt_wr_en),
    .tgt_wr_data (tgt_wr_data),
    .tgt_word    (tgt_word),
    .freq_meas   (freq_meas),
    .meas_valid  (meas_valid),
    .freq_err    (freq_err),
    .drive_mode  (drive_mode),
    .hs_en       (hs_en)
);

// File: tb/dvs_freq_err_unit_test.sv
module dvs_freq_err_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN_NS     = 100 * CLK_PERIOD;
    localparam int SPAN       = 64;

    logic       ref_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tgt_wr_en = 1'b0;
    logic [6:0] tgt_wr_data = '0;
    logic [6:0] freq_meas;
    logic       meas_valid;
    logic [7:0] freq_err;
    logic [1:0] drive_mode;
    logic       hs_en;
    logic       ls_en;

    int osc_half = 10;
    int checks = 0;
    int errors = 0;

    dvs_freq_err_unit uut (
        .ref_clk     (ref_clk),
        .osc_clk     (osc_clk),
        .rst_n       (rst_n),
        .tgt_wr_en   (tgt_wr_en),
        .tgt_wr_data (tgt_wr_data),
        .freq_meas   (freq_meas),
        .meas_valid  (meas_valid),
        .freq_err    (freq_err),
        .drive_mode  (drive_mode),
        .hs_en       (hs_en),
        .ls_en       (ls_en)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    // Oscillator model: edges on even times only, period chosen by supply level.
    initial forever begin
        #(osc_half);
        osc_clk = ~osc_clk;
    end

    function automatic int period_for_level(int lvl);
        case (lvl)
            0: return 200;
            1: return 40;
            2: return 20;
            3: return 8;
            default: return 4;
        endcase
    endfunction

    function automatic int exp_meas(int period);
        int n = WIN_NS / period;
        return (n > 127) ? 127 : n;
    endfunction

    function automatic int exp_mode(int err);
        if (err < 0) return 0;
        if (err == 0) return 1;
        if (err < 8) return 2;
        return 3;
    endfunction

    function automatic int exp_hs_span(int err);
        if (err <= 0) return 0;
        if (err < 8) return 3;
        return 4 * ((err > 16) ? 16 : err);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_tgt(int v);
        @(negedge ref_clk);
        tgt_wr_en   = 1'b1;
        tgt_wr_data = 7'(v);
        @(negedge ref_clk);
        tgt_wr_en   = 1'b0;
    endtask

    task automatic set_level(int lvl);
        osc_half = period_for_level(lvl) / 2;
        repeat (400) @(negedge ref_clk);
    endtask

    task automatic mod_case(int tgt, int meas, string req);
        int hs_cnt = 0;
        int ls_cnt = 0;
        int e = tgt - meas;
        write_tgt(tgt);
        repeat (100) @(negedge ref_clk);
        check(req, int'($signed(freq_err)), e);
        check(req, int'(drive_mode), exp_mode(e));
        for (int i = 0; i < SPAN; i++) begin
            @(negedge ref_clk);
            hs_cnt += int'(hs_en);
            ls_cnt += int'(ls_en);
        end
        check(req, hs_cnt, exp_hs_span(e));
        check("R10", ls_cnt, SPAN - hs_cnt);
    endtask

    initial begin
        repeat (150000) @(posedge ref_clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        int m;
        seed = $urandom(32'd2024);
        // R11: reset state
        repeat (5) @(negedge ref_clk);
        check("R11", int'(freq_meas), 0);
        check("R11", int'(freq_err), 0);
        check("R11", int'(hs_en), 0);
        check("R11", int'(ls_en), 1);
        rst_n = 1'b1;

        // R1: exact counts for periods dividing the window
        for (int lvl = 0; lvl < 4; lvl++) begin
            set_level(lvl);
            check("R1", int'(freq_meas), exp_meas(period_for_level(lvl)));
        end
        // R2: saturation
        set_level(4);
        check("R2", int'(freq_meas), 127);

        // R5: one-cycle valid pulse, measurement steady around it
        begin
            int pulses = 0;
            int longest = 0;
            int run = 0;
            for (int i = 0; i < 250; i++) begin
                @(negedge ref_clk);
                if (meas_valid) begin
                    pulses++;
                    run++;
                end else run = 0;
                if (run > longest) longest = run;
            end
            check("R5", (pulses >= 2) ? 1 : 0, 1);
            check("R5", longest, 1);
        end

        // R4/R3 random targets and supply levels
        for (int it = 0; it < 12; it++) begin
            int lvl = int'($urandom_range(0, 4));
            int t = int'($urandom_range(0, 127));
            set_level(lvl);
            write_tgt(t);
            repeat (3) @(negedge ref_clk);
            m = exp_meas(period_for_level(lvl));
            check("R1", int'(freq_meas), m);
            check("R4", int'($signed(freq_err)), t - m);
        end

        // R3: write strobe low leaves target unchanged
        set_level(2);
        write_tgt(60);
        repeat (3) @(negedge ref_clk);
        tgt_wr_data = 7'd5;
        repeat (20) @(negedge ref_clk);
        check("R3", int'($signed(freq_err)), 10);
        // R4 corner: largest and smallest errors
        set_level(4);
        write_tgt(0);
        repeat (3) @(negedge ref_clk);
        check("R4", int'($signed(freq_err)), -127);
        set_level(0);
        write_tgt(127);
        repeat (3) @(negedge ref_clk);
        check("R4", int'($signed(freq_err)), 122);

        // Modulator cases at 50 counts
        set_level(2);
        mod_case(50, 50, "R6");
        mod_case(51, 50, "R7");
        mod_case(57, 50, "R7");
        mod_case(58, 50, "R8");
        mod_case(61, 50, "R8");
        mod_case(66, 50, "R8");
        mod_case(100, 50, "R8");
        mod_case(49, 50, "R9");

        // R9: prompt block when error turns negative from full drive
        write_tgt(127);
        repeat (40) @(negedge ref_clk);
        check("R9", int'(hs_en), 1);
        write_tgt(0);
        repeat (2) @(negedge ref_clk);
        check("R9", int'(hs_en), 0);
        repeat (40) @(negedge ref_clk);
        check("R9", int'(drive_mode), 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule